// File: doc/BRIEF.md
# GPIO Port with Pad Modes

This block is a general-purpose I/O port of up to 32 pins for a chip's peripheral subsystem. Each pin has a configuration word that selects a pad mode and a pull setting. The modes are push-pull, open-drain, open-source, input, handed to a peripheral, or switched off. The pull settings are none, pull-up, pull-down, or a bus keeper that follows the pin's own sampled level. Drive strength, slew rate and the Schmitt-trigger enable are kept in the configuration word for the pad ring to use; this block does not act on them.

Software reaches the port through a small register bus. The bus has a whole-word write to the output register, reads of the output and input registers, and one configuration word per pin. Three mask inputs, set, clear and toggle, change output bits in one cycle without a read-modify-write. Pad inputs pass through a two-flop synchronizer into the input register.

When a pin leaves a non-driving mode for a driving mode, the same clock edge loads the pin's initial value into the output register. The pad therefore never shows the opposite level.

Top module: `gpio_port`

## Requirements
- R1: After reset the output register and input register read 0, every configuration word reads 0 (mode 0 = off, pull 0 = none), and every pad output enable and pull enable is low.
- R2: A bus write to address 0x00 replaces the output register. A nonzero `setMask`, `clearMask` or `toggleMask` updates the output register at the next clock edge. Reads of address 0x00 return the output register and reads of 0x01 return the input register.
- R3: Updates that arrive in the same cycle apply in this order: the word write first, then an initial-value load, then set (OR), then clear (AND with the inverted mask), then toggle (XOR).
- R4: Mode 2 (push-pull) asserts output enable and drives the output bit onto the pad.
- R5: Mode 3 (open-drain) drives the pad low when the output bit is 0 and releases the pad (output enable low) when the output bit is 1.
- R6: Mode 4 (open-source) drives the pad high when the output bit is 1 and releases the pad when the output bit is 0.
- R7: Mode 5 (peripheral) passes `periphOut` and `periphOe` of that pin straight to the pad.
- R8: The pull field works as follows:
  - 0 enables neither pull.
  - 1 enables the pull-up.
  - 2 enables the pull-down.
  - 3 (keeper) enables the pull-up when the pin's input-register bit is 1 and the pull-down when it is 0.
- R9: A pad input level shows up in the input register after two clock edges.
- R10: A pin in mode 0, 6 or 7 (off) has output enable low and its input-register bit frozen. Its requested pull is still applied.
- R11: A configuration write that moves a pin from mode 0, 1, 5, 6 or 7 to mode 2, 3 or 4 loads bit 10 of the written word into the pin's output bit on the same edge as the mode change. A write to a pin that is already in a driving mode leaves the output bit alone.
- R12: The configuration word of pin n is at address 0x20+n. Its fields are:
  - bits [2:0]: mode
  - bits [4:3]: pull
  - bits [6:5]: drive strength
  - bits [8:7]: slew rate
  - bit 9: Schmitt enable

  A read returns the stored fields plus, in bit 10, the pin's current value. That value is the input-register bit in mode 1 and the output-register bit in every other mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Bus write strobe |
| wrAddr | input | 6 | Bus write address |
| wrData | input | 32 | Bus write data |
| rdAddr | input | 6 | Bus read address |
| rdData | output | 32 | Bus read data, combinational from rdAddr |
| setMask | input | PIN_COUNT | Output bits to set this cycle |
| clearMask | input | PIN_COUNT | Output bits to clear this cycle |
| toggleMask | input | PIN_COUNT | Output bits to invert this cycle |
| padIn | input | PIN_COUNT | Raw pad input levels |
| periphOut | input | PIN_COUNT | Peripheral output values |
| periphOe | input | PIN_COUNT | Peripheral output enables |
| padOut | output | PIN_COUNT | Pad output values |
| padOe | output | PIN_COUNT | Pad output enables |
| padPullUp | output | PIN_COUNT | Pad pull-up enables |
| padPullDn | output | PIN_COUNT | Pad pull-down enables |

## Verification
The output register, the configuration words and the initial-value load all change at the first clock edge after the write or mask. Pad outputs and bus reads are combinational from those registers, so their results are due one edge after the stimulus. An input level needs two edges before it reaches the input register and the keeper pull. The bench drives on the falling edge and samples on the next falling edge for one-edge results. For the synchronizer it samples after the first edge to confirm the value has not yet arrived, and again after the second. The random phase applies masks and word writes together and compares every cycle against a model of the update order.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 6;
  localparam int IDX_W  = 5;
  localparam int CFG_W  = 10;
  localparam int INIT_BIT = 10;

  localparam logic [2:0] MODE_OFF = 3'd0;
  localparam logic [2:0] MODE_IN  = 3'd1;
  localparam logic [2:0] MODE_PP  = 3'd2;
  localparam logic [2:0] MODE_OD  = 3'd3;
  localparam logic [2:0] MODE_OS  = 3'd4;
  localparam logic [2:0] MODE_ALT = 3'd5;

  localparam logic [1:0] PULL_NONE = 2'd0;
  localparam logic [1:0] PULL_UP   = 2'd1;
  localparam logic [1:0] PULL_DN   = 2'd2;
  localparam logic [1:0] PULL_KEEP = 2'd3;

  localparam logic [1:0] RD_NONE = 2'd0;
  localparam logic [1:0] RD_OUT  = 2'd1;
  localparam logic [1:0] RD_IN   = 2'd2;
  localparam logic [1:0] RD_CFG  = 2'd3;

  localparam logic [ADDR_W-1:0] ADDR_OUT = 6'h00;
  localparam logic [ADDR_W-1:0] ADDR_IN  = 6'h01;

  typedef struct packed {
    logic             wordWr;
    logic             cfgWr;
    logic [IDX_W-1:0] wrIdx;
    logic [1:0]       rdSel;
    logic [IDX_W-1:0] rdIdx;
  } strobe_t;

  function automatic logic isDrive(input logic [2:0] m);
    return (m == MODE_PP) || (m == MODE_OD) || (m == MODE_OS);
  endfunction

  function automatic logic isOff(input logic [2:0] m);
    return !((m == MODE_IN) || (m == MODE_ALT) || isDrive(m));
  endfunction
endpackage

// File: rtl/gpio_ctrl.sv
module gpio_ctrl
  import gpio_pkg::*;
#(
  parameter int PIN_COUNT = 32
) (
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [ADDR_W-1:0] rdAddr,
  output strobe_t           strobe
);
  localparam logic [ADDR_W-1:0] PIN_LIMIT = ADDR_W'(PIN_COUNT);

  logic wrCfgHit;
  logic rdCfgHit;

  assign wrCfgHit = wrAddr[ADDR_W-1] && ({1'b0, wrAddr[IDX_W-1:0]} < PIN_LIMIT);
  assign rdCfgHit = rdAddr[ADDR_W-1] && ({1'b0, rdAddr[IDX_W-1:0]} < PIN_LIMIT);

  always_comb begin
    strobe        = '0;
    strobe.wrIdx  = wrAddr[IDX_W-1:0];
    strobe.rdIdx  = rdAddr[IDX_W-1:0];
    if (wrEn) begin
      if (wrAddr == ADDR_OUT) strobe.wordWr = 1'b1;
      else if (wrCfgHit)      strobe.cfgWr  = 1'b1;
    end
    if (rdAddr == ADDR_OUT)     strobe.rdSel = RD_OUT;
    else if (rdAddr == ADDR_IN) strobe.rdSel = RD_IN;
    else if (rdCfgHit)          strobe.rdSel = RD_CFG;
    else                        strobe.rdSel = RD_NONE;
  end
endmodule

// File: rtl/gpio_datapath.sv
module gpio_datapath
  import gpio_pkg::*;
#(
  parameter int PIN_COUNT = 32
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  strobe_t                       strobe,
  input  logic [DATA_W-1:0]             wrData,
  input  logic [PIN_COUNT-1:0]          setMask,
  input  logic [PIN_COUNT-1:0]          clearMask,
  input  logic [PIN_COUNT-1:0]          toggleMask,
  input  logic [PIN_COUNT-1:0]          padIn,
  input  logic [PIN_COUNT-1:0]          periphOut,
  input  logic [PIN_COUNT-1:0]          periphOe,
  output logic [PIN_COUNT-1:0]          padOut,
  output logic [PIN_COUNT-1:0]          padOe,
  output logic [PIN_COUNT-1:0]          padPullUp,
  output logic [PIN_COUNT-1:0]          padPullDn,
  output logic [DATA_W-1:0]             rdData,
  output logic [PIN_COUNT-1:0]          outBits,
  output logic [PIN_COUNT-1:0]          inBits,
  output logic [PIN_COUNT-1:0][2:0]     modeVec,
  output logic [PIN_COUNT-1:0][1:0]     pullVec
);
  logic [PIN_COUNT-1:0][CFG_W-1:0] cfgReg;
  logic [PIN_COUNT-1:0]            outReg;
  logic [PIN_COUNT-1:0]            nextOut;
  logic [PIN_COUNT-1:0]            syncA;
  logic [PIN_COUNT-1:0]            syncB;
  logic                            loadInit;
  logic [2:0]                      curWrMode;
  logic [2:0]                      curRdMode;
  logic                            curValue;

  assign curWrMode = cfgReg[strobe.wrIdx][2:0];
  assign loadInit  = strobe.cfgWr && isDrive(wrData[2:0]) && !isDrive(curWrMode);

  // Update order: word write, initial value, set, clear, toggle
  always_comb begin
    nextOut = outReg;
    if (strobe.wordWr) nextOut = wrData[PIN_COUNT-1:0];
    if (loadInit) nextOut[strobe.wrIdx] = wrData[INIT_BIT];
    nextOut = nextOut | setMask;
    nextOut = nextOut & ~clearMask;
    nextOut = nextOut ^ toggleMask;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) outReg <= '0;
    else       outReg <= nextOut;
  end

  generate
    for (genvar p = 0; p < PIN_COUNT; p++) begin : g_pin
      logic [2:0] mode;
      logic [1:0] pull;
      logic       sampleEn;

      assign mode     = cfgReg[p][2:0];
      assign pull     = cfgReg[p][4:3];
      assign sampleEn = !isOff(mode);

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          cfgReg[p] <= '0;
        end else if (strobe.cfgWr && (strobe.wrIdx == IDX_W'(p))) begin
          cfgReg[p] <= wrData[CFG_W-1:0];
        end
      end

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          syncA[p] <= 1'b0;
          syncB[p] <= 1'b0;
        end else if (sampleEn) begin
          syncA[p] <= padIn[p];
          syncB[p] <= syncA[p];
        end
      end

      always_comb begin
        unique case (mode)
          MODE_PP: begin padOe[p] = 1'b1;        padOut[p] = outReg[p];    end
          MODE_OD: begin padOe[p] = !outReg[p];  padOut[p] = 1'b0;         end
          MODE_OS: begin padOe[p] = outReg[p];   padOut[p] = 1'b1;         end
          MODE_ALT: begin padOe[p] = periphOe[p]; padOut[p] = periphOut[p]; end
          default: begin padOe[p] = 1'b0;        padOut[p] = 1'b0;         end
        endcase
      end

      always_comb begin
        unique case (pull)
          PULL_UP:   begin padPullUp[p] = 1'b1;     padPullDn[p] = 1'b0;      end
          PULL_DN:   begin padPullUp[p] = 1'b0;     padPullDn[p] = 1'b1;      end
          PULL_KEEP: begin padPullUp[p] = syncB[p]; padPullDn[p] = !syncB[p]; end
          default:   begin padPullUp[p] = 1'b0;     padPullDn[p] = 1'b0;      end
        endcase
      end

      assign modeVec[p] = mode;
      assign pullVec[p] = pull;
    end
  endgenerate

  assign curRdMode = cfgReg[strobe.rdIdx][2:0];
  assign curValue  = (curRdMode == MODE_IN) ? syncB[strobe.rdIdx] : outReg[strobe.rdIdx];

  always_comb begin
    rdData = '0;
    unique case (strobe.rdSel)
      RD_OUT: rdData[PIN_COUNT-1:0] = outReg;
      RD_IN:  rdData[PIN_COUNT-1:0] = syncB;
      RD_CFG: begin
        rdData[CFG_W-1:0] = cfgReg[strobe.rdIdx];
        rdData[INIT_BIT]  = curValue;
      end
      default: rdData = '0;
    endcase
  end

  assign outBits = outReg;
  assign inBits  = syncB;
endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_pkg::*;
#(
  parameter int PIN_COUNT = 32
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 wrEn,
  input  logic [5:0]           wrAddr,
  input  logic [31:0]          wrData,
  input  logic [5:0]           rdAddr,
  output logic [31:0]          rdData,
  input  logic [PIN_COUNT-1:0] setMask,
  input  logic [PIN_COUNT-1:0] clearMask,
  input  logic [PIN_COUNT-1:0] toggleMask,
  input  logic [PIN_COUNT-1:0] padIn,
  input  logic [PIN_COUNT-1:0] periphOut,
  input  logic [PIN_COUNT-1:0] periphOe,
  output logic [PIN_COUNT-1:0] padOut,
  output logic [PIN_COUNT-1:0] padOe,
  output logic [PIN_COUNT-1:0] padPullUp,
  output logic [PIN_COUNT-1:0] padPullDn
);
  strobe_t                      strobe;
  logic [PIN_COUNT-1:0]         outBits;
  logic [PIN_COUNT-1:0]         inBits;
  logic [PIN_COUNT-1:0][2:0]    modeVec;
  logic [PIN_COUNT-1:0][1:0]    pullVec;

  gpio_ctrl #(.PIN_COUNT(PIN_COUNT)) u_ctrl (
    .wrEn   (wrEn),
    .wrAddr (wrAddr),
    .rdAddr (rdAddr),
    .strobe (strobe)
  );

  gpio_datapath #(.PIN_COUNT(PIN_COUNT)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .wrData     (wrData),
    .setMask    (setMask),
    .clearMask  (clearMask),
    .toggleMask (toggleMask),
    .padIn      (padIn),
    .periphOut  (periphOut),
    .periphOe   (periphOe),
    .padOut     (padOut),
    .padOe      (padOe),
    .padPullUp  (padPullUp),
    .padPullDn  (padPullDn),
    .rdData     (rdData),
    .outBits    (outBits),
    .inBits     (inBits),
    .modeVec    (modeVec),
    .pullVec    (pullVec)
  );
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk
  import gpio_pkg::*;
#(
  parameter int PIN_COUNT = 32
) (
  input logic                      clk,
  input logic                      rstN,
  input logic                      wrEn,
  input logic [PIN_COUNT-1:0]      setMask,
  input logic [PIN_COUNT-1:0]      clearMask,
  input logic [PIN_COUNT-1:0]      toggleMask,
  input logic [PIN_COUNT-1:0]      outBits,
  input logic [PIN_COUNT-1:0]      inBits,
  input logic [PIN_COUNT-1:0][2:0] modeVec,
  input logic [PIN_COUNT-1:0][1:0] pullVec,
  input logic [PIN_COUNT-1:0]      padOut,
  input logic [PIN_COUNT-1:0]      padOe,
  input logic [PIN_COUNT-1:0]      padPullUp,
  input logic [PIN_COUNT-1:0]      padPullDn,
  input logic [PIN_COUNT-1:0]      periphOut,
  input logic [PIN_COUNT-1:0]      periphOe
);
  // R3
  mask_order_chk: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |=> outBits == $past(((outBits | setMask) & ~clearMask) ^ toggleMask));

  generate
    for (genvar p = 0; p < PIN_COUNT; p++) begin : g_chk
      // R4
      push_pull_chk: assert property (@(posedge clk) disable iff (!rstN)
        (modeVec[p] == MODE_PP) |-> (padOe[p] && (padOut[p] == outBits[p])));
      // R5
      open_drain_chk: assert property (@(posedge clk) disable iff (!rstN)
        (modeVec[p] == MODE_OD) |-> (!padOut[p] && (padOe[p] == !outBits[p])));
      // R6
      open_source_chk: assert property (@(posedge clk) disable iff (!rstN)
        (modeVec[p] == MODE_OS) |-> (padOut[p] && (padOe[p] == outBits[p])));
      // R7
      periph_pass_chk: assert property (@(posedge clk) disable iff (!rstN)
        (modeVec[p] == MODE_ALT) |-> ((padOe[p] == periphOe[p]) && (padOut[p] == periphOut[p])));
      // R8
      keeper_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
        (pullVec[p] == PULL_KEEP) |-> ((padPullUp[p] == inBits[p]) && (padPullDn[p] == !inBits[p])));
      // R10
      off_release_chk: assert property (@(posedge clk) disable iff (!rstN)
        isOff(modeVec[p]) |-> !padOe[p]);
      // R10
      off_freeze_chk: assert property (@(posedge clk) disable iff (!rstN)
        isOff(modeVec[p]) |=> $stable(inBits[p]));
    end
  endgenerate
endmodule

bind gpio_port gpio_port_chk #(.PIN_COUNT(PIN_COUNT)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .wrEn       (wrEn),
  .setMask    (setMask),
  .clearMask  (clearMask),
  .toggleMask (toggleMask),
  .outBits    (outBits),
  .inBits     (inBits),
  .modeVec    (modeVec),
  .pullVec    (pullVec),
  .padOut     (padOut),
  .padOe      (padOe),
  .padPullUp  (padPullUp),
  .padPullDn  (padPullDn),
  .periphOut  (periphOut),
  .periphOe   (periphOe)
);

// File: tb/tb_gpio_port.sv
module tb_gpio_port;
  localparam int N = 32;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          wrEn = 1'b0;
  logic [5:0]    wrAddr = '0;
  logic [31:0]   wrData = '0;
  logic [5:0]    rdAddr = '0;
  logic [31:0]   rdData;
  logic [N-1:0]  setMask = '0, clearMask = '0, toggleMask = '0;
  logic [N-1:0]  padIn = '0, periphOut = '0, periphOe = '0;
  logic [N-1:0]  padOut, padOe, padPullUp, padPullDn;

  int nChecks = 0;
  int nFails  = 0;
  logic [31:0] expOut = '0;
  logic [31:0] v;

  gpio_port #(.PIN_COUNT(N)) dut (.*);

  always #5 clk = ~clk;

  function automatic logic [31:0] model(input logic [31:0] base, s, c, t);
    return ((base | s) & ~c) ^ t;
  endfunction

  function automatic logic [31:0] cfgWord(input int mode, pull, drv, slew, schm, init);
    return 32'(mode) | (32'(pull) << 3) | (32'(drv) << 5) | (32'(slew) << 7)
         | (32'(schm) << 9) | (32'(init) << 10);
  endfunction

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [5:0] a, input logic [31:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    tick();
    wrEn = 1'b0;
  endtask

  task automatic busRead(input logic [5:0] a, output logic [31:0] d);
    rdAddr = a;
    #1;
    d = rdData;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed1234));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    busRead(6'h00, v); check("R1 out", v, 32'h0);
    busRead(6'h01, v); check("R1 in", v, 32'h0);
    busRead(6'h20, v); check("R1 cfg0", v, 32'h0);
    check("R1 oe", padOe, 32'h0);
    check("R1 pulls", padPullUp | padPullDn, 32'h0);

    // R2 whole-word write
    busWrite(6'h00, 32'hA5A5_0F0F);
    busRead(6'h00, v); check("R2 word write", v, 32'hA5A5_0F0F);
    busWrite(6'h00, 32'h0);

    // R3 same-cycle set/clear/toggle on bit0 -> 1, on bit1 set+clear -> 0
    setMask = 32'h3; clearMask = 32'h3; toggleMask = 32'h1;
    tick();
    setMask = '0; clearMask = '0; toggleMask = '0;
    busRead(6'h00, v); check("R3 order", v, 32'h1);
    // R3 word write with toggle in same cycle
    wrEn = 1'b1; wrAddr = 6'h00; wrData = 32'hF0; toggleMask = 32'h11;
    tick();
    wrEn = 1'b0; toggleMask = '0;
    busRead(6'h00, v); check("R3 word then toggle", v, 32'hE1);
    busWrite(6'h00, 32'h0);

    // R11 + R4: push-pull on pin2 with initial value 1
    busWrite(6'h22, cfgWord(2, 0, 0, 0, 0, 1));
    check("R11 pp init oe", 32'(padOe[2]), 32'h1);
    check("R11 pp init out", 32'(padOut[2]), 32'h1);
    clearMask = 32'h4; tick(); clearMask = '0;
    check("R4 pp low", {30'h0, padOe[2], padOut[2]}, 32'h2);

    // R5 open-drain pin3, init 1 = released
    busWrite(6'h23, cfgWord(3, 1, 0, 0, 0, 1));
    check("R5 od release", 32'(padOe[3]), 32'h0);
    clearMask = 32'h8; tick(); clearMask = '0;
    check("R5 od drive low", {30'h0, padOe[3], padOut[3]}, 32'h2);

    // R6 open-source pin4, init 0 = released
    busWrite(6'h24, cfgWord(4, 0, 0, 0, 0, 0));
    check("R6 os release", 32'(padOe[4]), 32'h0);
    setMask = 32'h10; tick(); setMask = '0;
    check("R6 os drive high", {30'h0, padOe[4], padOut[4]}, 32'h3);
    // R11 no init load when already driving
    busWrite(6'h24, cfgWord(4, 0, 0, 0, 0, 0));
    busRead(6'h00, v); check("R11 no reload", v & 32'h10, 32'h10);

    // R7 peripheral pin7
    busWrite(6'h27, cfgWord(5, 0, 0, 0, 0, 0));
    periphOe[7] = 1'b1; periphOut[7] = 1'b1; #1;
    check("R7 periph high", {30'h0, padOe[7], padOut[7]}, 32'h3);
    periphOut[7] = 1'b0; periphOe[7] = 1'b0; #1;
    check("R7 periph off", {30'h0, padOe[7], padOut[7]}, 32'h0);

    // R9 + R8 keeper on input pin5
    busWrite(6'h25, cfgWord(1, 3, 0, 0, 0, 0));
    check("R8 keeper low", {30'h0, padPullUp[5], padPullDn[5]}, 32'h1);
    padIn[5] = 1'b1;
    tick();
    busRead(6'h01, v); check("R9 one edge", v & 32'h20, 32'h0);
    tick();
    busRead(6'h01, v); check("R9 two edges", v & 32'h20, 32'h20);
    check("R8 keeper high", {30'h0, padPullUp[5], padPullDn[5]}, 32'h2);
    busRead(6'h25, v); check("R12 input value", v, cfgWord(1, 3, 0, 0, 0, 1));
    padIn[5] = 1'b0; tick(); tick();
    check("R8 keeper back low", {30'h0, padPullUp[5], padPullDn[5]}, 32'h1);

    // R8 fixed pulls
    busWrite(6'h28, cfgWord(1, 1, 0, 0, 0, 0));
    busWrite(6'h29, cfgWord(1, 2, 0, 0, 0, 0));
    check("R8 up/down", {28'h0, padPullUp[8], padPullDn[8], padPullUp[9], padPullDn[9]}, 32'h9);

    // R10 off pin6 with pull-up, reserved mode 7 on pin10
    busWrite(6'h26, cfgWord(0, 1, 0, 0, 0, 0));
    busWrite(6'h2A, cfgWord(7, 0, 0, 0, 0, 0));
    padIn[6] = 1'b1; padIn[10] = 1'b1;
    tick(); tick(); tick();
    busRead(6'h01, v); check("R10 frozen", v & 32'h440, 32'h0);
    check("R10 oe low", {30'h0, padOe[6], padOe[10]}, 32'h0);
    check("R10 pull kept", 32'(padPullUp[6]), 32'h1);
    padIn[6] = 1'b0; padIn[10] = 1'b0;

    // R12 field storage and output-side readback
    busWrite(6'h2B, cfgWord(1, 2, 3, 1, 1, 0));
    busRead(6'h2B, v); check("R12 fields", v, cfgWord(1, 2, 3, 1, 1, 0));
    busRead(6'h22, v); check("R12 out value 0", v[10], 1'b0);
    setMask = 32'h4; tick(); setMask = '0;
    busRead(6'h22, v); check("R12 out value 1", v[10], 1'b1);

    // R2/R3 constrained random mask and word traffic
    busRead(6'h00, expOut);
    rdAddr = 6'h00;
    for (int i = 0; i < 400; i++) begin
      logic doWord;
      logic [31:0] wd, s, c, t;
      doWord = ($urandom % 4) == 0;
      wd = $urandom;
      s = $urandom & $urandom;
      c = $urandom & $urandom;
      t = ($urandom % 3 == 0) ? ($urandom & $urandom & $urandom) : 32'h0;
      wrEn = doWord; wrAddr = 6'h00; wrData = wd;
      setMask = s; clearMask = c; toggleMask = t;
      tick();
      wrEn = 1'b0; setMask = '0; clearMask = '0; toggleMask = '0;
      expOut = model(doWord ? wd : expOut, s, c, t);
      busRead(6'h00, v);
      check("R3 random", v, expOut);
    end

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule